// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a ring of transmit descriptors held in a word-addressed memory and turns the buffers they point to into a byte stream for a MAC transmitter. Each descriptor is a pair of words: a buffer pointer and a control word. The control word carries the byte count, the end-of-frame mark, the no-CRC request, a ring-wrap mark and an ownership flag. Software hands a buffer to the block by clearing the ownership flag. The block marks the buffer as its own again, together with the completion status, once every byte of that buffer has been accepted downstream.

Software starts the block with a command write that sets transmit enable and start together. The block then works forward from its current descriptor and stops when it meets a descriptor it already owns. A halt request lets the frame in flight finish before the block stops, and a later start carries on from the next descriptor. Clearing transmit enable stops at once and sends the descriptor index back to the ring base. A frame cut short by an owned descriptor part way through is aborted, and its first descriptor is flagged.

Top module: `txr_ring_reader`

## Requirements
- R1: Descriptor n sits at word addresses base+2n (buffer word address) and base+2n+1 (control word). Memory read data is used the cycle after `mem_rd`, and the block never asserts `mem_rd` and `mem_we` together.
- R2: Control bits 10:0 give the buffer length in bytes. Bytes are taken from consecutive words starting at the buffer address, least significant byte first. Every buffer starts at byte lane 0, and a length of zero sends nothing.
- R3: `tx_last` is high only on the final byte of a descriptor whose control bit 15 is set. Buffers of descriptors without bit 15 are joined into a single frame.
- R4: `tx_nocrc` on each byte copies control bit 16 of the descriptor that byte came from.
- R5: A descriptor whose control bit 31 is 1 when a frame is about to begin ends fetching. It is not written, no byte is sent and `tx_go` falls.
- R6: After the last byte of a buffer is accepted, the block rewrites that control word with bit 31 set and every other bit kept. On a frame's final descriptor it also sets bit 28 if `mac_underrun` pulsed during the frame and bit 29 if `mac_retry_lim` pulsed.
- R7: After a descriptor with control bit 30 set, the next descriptor fetched is descriptor 0 at the ring base.
- R8: A command write with `cmd_tx_en`=1 and `cmd_start`=1 while stopped raises `tx_go` on the next cycle and begins at the current descriptor.
- R9: A command write with `cmd_halt`=1 lets the current frame finish. `tx_go` stays high until that frame's last write-back and then falls. The next start resumes at the following descriptor.
- R10: A command write with `cmd_tx_en`=0 drops `tx_go` and `tx_valid` on the next cycle and resets the descriptor index to 0.
- R11: If a descriptor met inside a frame has bit 31 set, the frame stops with no `tx_last`. The first descriptor of that frame is rewritten with bits 31 and 27 set and its other bits kept, and `tx_go` falls.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R13: `rx_enable` follows `cmd_rx_en` of the latest command write and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_tx_en | input | 1 | Transmit enable field |
| cmd_rx_en | input | 1 | Receive enable field |
| cmd_start | input | 1 | Start field |
| cmd_halt | input | 1 | Halt request field |
| base_wr | input | 1 | Ring base register write strobe |
| base_in | input | AW | Ring base word address |
| tx_go | output | 1 | Transmit busy status |
| rx_enable | output | 1 | Stored receive enable |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| tx_valid | output | 1 | Byte valid to MAC |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Byte to MAC |
| tx_last | output | 1 | Final byte of frame |
| tx_nocrc | output | 1 | MAC must not append CRC |
| mac_underrun | input | 1 | MAC underrun pulse |
| mac_retry_lim | input | 1 | MAC retry-limit pulse |

## Verification
The assertions assume the memory returns read data exactly one cycle after a read and serves nothing else during that cycle. They also assume that software leaves the ring base and the descriptors the block owns alone while `tx_go` is high, and that disabling transmit is the only way a pending byte may be withdrawn. The bench keeps to these rules. It writes descriptors and buffers only while the block is stopped, or before the block can reach them. It changes the base only between runs, and it checks byte holding only under the two stalling ready patterns, where no disable is issued. The sweeps cover buffer lengths from 0 to 9 under three ready patterns, with the expected bytes computed from a seeded formula.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int LEN_W   = 11;
  localparam int B_LAST  = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UNDR  = 28;
  localparam int B_RETRY = 29;
  localparam int B_WRAP  = 30;
  localparam int B_OWNED = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_WT_CTRL, S_RD_ADDR, S_WT_ADDR,
    S_RD_DATA, S_WT_DATA, S_SEND, S_DRAIN, S_WB, S_ABORT
  } txr_state_e;
endpackage

// File: rtl/txr_cmd_regs.sv
module txr_cmd_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          cmd_tx_en,
  input  logic          cmd_rx_en,
  input  logic          cmd_start,
  input  logic          cmd_halt,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          halt_clr,
  output logic          rx_en_q,
  output logic [AW-1:0] base_q,
  output logic          halt_pend,
  output logic          start_pls,
  output logic          dis_pls
);
  logic halt_set;

  assign start_pls = cmd_wr & cmd_tx_en & cmd_start;
  assign dis_pls   = cmd_wr & ~cmd_tx_en;
  assign halt_set  = cmd_wr & cmd_tx_en & cmd_halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_q   <= 1'b0;
      base_q    <= '0;
      halt_pend <= 1'b0;
    end else begin
      if (cmd_wr) rx_en_q <= cmd_rx_en;
      if (base_wr) base_q <= base_in;
      if (halt_clr || dis_pls) halt_pend <= 1'b0;
      else if (halt_set) halt_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr
);
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (adv) idx <= wrap ? '0 : idx + IW'(1);
  end

  assign desc_addr = base + AW'({idx, 1'b0});
endmodule

// File: rtl/txr_ring_reader.sv
module txr_ring_reader
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          cmd_tx_en,
  input  logic          cmd_rx_en,
  input  logic          cmd_start,
  input  logic          cmd_halt,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  output logic          tx_go,
  output logic          rx_enable,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_nocrc,
  input  logic          mac_underrun,
  input  logic          mac_retry_lim
);
  txr_state_e        state;
  logic [AW-1:0]     base_q, desc_addr, buf_ptr, first_addr;
  logic [31:0]       ctrl_q, word_q, first_ctrl, wb_word;
  logic [LEN_W-1:0]  rem;
  logic [1:0]        lane;
  logic              in_frame, flg_undr, flg_retry;
  logic              halt_pend, start_pls, dis_pls, halt_clr, frame_end;

  assign frame_end = ctrl_q[B_LAST];
  assign halt_clr  = (state == S_IDLE) || (state == S_WB && frame_end);

  txr_cmd_regs #(.AW(AW)) cmd_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_tx_en(cmd_tx_en),
    .cmd_rx_en(cmd_rx_en), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
    .base_wr(base_wr), .base_in(base_in), .halt_clr(halt_clr),
    .rx_en_q(rx_enable), .base_q(base_q), .halt_pend(halt_pend),
    .start_pls(start_pls), .dis_pls(dis_pls)
  );

  txr_ring_ptr #(.AW(AW), .IW(IW)) ptr_i (
    .clk(clk), .rst(rst), .base(base_q), .clr(dis_pls),
    .adv(state == S_WB), .wrap(ctrl_q[B_WRAP]), .desc_addr(desc_addr)
  );

  assign tx_go = (state != S_IDLE);

  always_comb begin
    wb_word = ctrl_q | (32'd1 << B_OWNED);
    if (frame_end)
      wb_word = wb_word | ({30'd0, flg_retry, flg_undr} << B_UNDR);
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (state)
      S_RD_CTRL: begin mem_rd = 1'b1; mem_addr = desc_addr + AW'(1); end
      S_RD_ADDR: begin mem_rd = 1'b1; mem_addr = desc_addr; end
      S_RD_DATA: begin mem_rd = 1'b1; mem_addr = buf_ptr; end
      S_WB: begin
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(1);
        mem_wdata = wb_word;
      end
      S_ABORT: begin
        mem_we    = 1'b1;
        mem_addr  = first_addr + AW'(1);
        mem_wdata = first_ctrl | (32'd1 << B_OWNED) | (32'd1 << B_EXH);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ctrl_q     <= '0;
      word_q     <= '0;
      buf_ptr    <= '0;
      first_addr <= '0;
      first_ctrl <= '0;
      rem        <= '0;
      lane       <= '0;
      in_frame   <= 1'b0;
      flg_undr   <= 1'b0;
      flg_retry  <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      tx_last    <= 1'b0;
      tx_nocrc   <= 1'b0;
    end else if (dis_pls) begin
      state    <= S_IDLE;
      in_frame <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (in_frame && mac_underrun)  flg_undr  <= 1'b1;
      if (in_frame && mac_retry_lim) flg_retry <= 1'b1;
      case (state)
        S_IDLE:    if (start_pls) state <= S_RD_CTRL;
        S_RD_CTRL: state <= S_WT_CTRL;
        S_WT_CTRL: begin
          ctrl_q <= mem_rdata;
          if (mem_rdata[B_OWNED]) begin
            state <= in_frame ? S_ABORT : S_IDLE;
          end else begin
            state <= S_RD_ADDR;
            rem   <= mem_rdata[LEN_W-1:0];
            if (!in_frame) begin
              in_frame   <= 1'b1;
              first_addr <= desc_addr;
              first_ctrl <= mem_rdata;
              flg_undr   <= 1'b0;
              flg_retry  <= 1'b0;
            end
          end
        end
        S_RD_ADDR: state <= S_WT_ADDR;
        S_WT_ADDR: begin
          buf_ptr <= mem_rdata[AW-1:0];
          lane    <= '0;
          state   <= (rem == '0) ? S_DRAIN : S_RD_DATA;
        end
        S_RD_DATA: state <= S_WT_DATA;
        S_WT_DATA: begin
          word_q <= mem_rdata;
          state  <= S_SEND;
        end
        S_SEND: begin
          if (!tx_valid || tx_ready) begin
            tx_valid <= 1'b1;
            tx_data  <= word_q[{lane, 3'b000} +: 8];
            tx_last  <= (rem == LEN_W'(1)) && frame_end;
            tx_nocrc <= ctrl_q[B_NOCRC];
            rem      <= rem - LEN_W'(1);
            lane     <= lane + 2'd1;
            if (rem == LEN_W'(1)) begin
              state <= S_DRAIN;
            end else if (lane == 2'd3) begin
              buf_ptr <= buf_ptr + AW'(1);
              state   <= S_RD_DATA;
            end
          end
        end
        S_DRAIN: if (!tx_valid || tx_ready) state <= S_WB;
        S_WB: begin
          if (frame_end) begin
            in_frame <= 1'b0;
            state    <= halt_pend ? S_IDLE : S_RD_CTRL;
          end else begin
            state <= S_RD_CTRL;
          end
        end
        S_ABORT: begin
          in_frame <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_ring_reader_chk.sv
module txr_ring_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wr,
  input logic       cmd_tx_en,
  input logic       cmd_start,
  input logic       tx_go,
  input logic       mem_rd,
  input logic       mem_we,
  input logic       wb_owned,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last
);
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we)); // R1
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_go |-> (!mem_rd && !mem_we)); // R5
  AST_WB_OWNED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wb_owned); // R6
  AST_WB_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !tx_valid); // R6
  AST_START_GO: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_tx_en && cmd_start && !tx_go) |=> tx_go); // R8
  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_tx_en) |=> (!tx_go && !tx_valid)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(cmd_wr && !cmd_tx_en))
      |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R12
endmodule

bind txr_ring_reader txr_ring_reader_chk chk_i (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_tx_en(cmd_tx_en),
  .cmd_start(cmd_start), .tx_go(tx_go), .mem_rd(mem_rd), .mem_we(mem_we),
  .wb_owned(mem_wdata[31]), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/txr_ring_reader_tb_top.sv
`timescale 1ns/1ps
module txr_ring_reader_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] LST = 32'h0000_8000;
  localparam logic [31:0] NOC = 32'h0001_0000;
  localparam logic [31:0] WRP = 32'h4000_0000;
  localparam logic [31:0] EXH = 32'h0800_0000;
  localparam logic [31:0] UDR = 32'h1000_0000;
  localparam logic [31:0] RTY = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 0, cmd_tx_en = 0, cmd_rx_en = 0, cmd_start = 0, cmd_halt = 0;
  logic base_wr = 0;
  logic [AW-1:0] base_in = '0;
  logic tx_go, rx_enable, mem_rd, mem_we, tx_valid, tx_last, tx_nocrc;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic mac_underrun = 0, mac_retry_lim = 0;

  logic tb_we = 0;
  logic [7:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mem [0:255];

  int errs = 0, checks = 0, merrs = 0, mchecks = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int rx_n = 0;
  logic [7:0] rx_b [0:1023];
  logic rx_l [0:1023];
  logic rx_c [0:1023];
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #2 clk = ~clk;

  txr_ring_reader #(.AW(AW), .IW(8)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_tx_en(cmd_tx_en),
    .cmd_rx_en(cmd_rx_en), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
    .base_wr(base_wr), .base_in(base_in), .tx_go(tx_go), .rx_enable(rx_enable),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_nocrc(tx_nocrc),
    .mac_underrun(mac_underrun), .mac_retry_lim(mac_retry_lim)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // Stream monitor: chooses tx_ready, records accepted bytes, checks holding (R12)
  always @(negedge clk) begin
    cyc = cyc + 1;
    case (rdy_mode)
      1: tx_ready = cyc[0];
      2: tx_ready = (cyc % 3 == 0);
      default: tx_ready = 1'b1;
    endcase
    if (rst) prev_stall = 1'b0;
    else begin
      if (prev_stall) begin
        mchecks = mchecks + 1;
        if (!(tx_valid && tx_data == prev_data)) begin
          merrs = merrs + 1;
          $display("FAIL R12 stalled byte changed: actual %0d/%02h expected 1/%02h",
                   tx_valid, tx_data, prev_data);
        end
      end
      prev_stall = tx_valid && !tx_ready && (rdy_mode != 0);
      prev_data  = tx_data;
    end
    if (tx_valid && tx_ready && rx_n < 1024) begin
      rx_b[rx_n] = tx_data;
      rx_l[rx_n] = tx_last;
      rx_c[rx_n] = tx_nocrc;
      rx_n = rx_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mem(input int a, input logic [31:0] d);
    tb_addr = 8'(a); tb_data = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic fill_buf(input int b, input int len, input int s);
    for (int w = 0; w < (len + 3) / 4; w++)
      wr_mem(b + w, {pat(s, 4*w+3), pat(s, 4*w+2), pat(s, 4*w+1), pat(s, 4*w)});
  endtask

  task automatic do_cmd(input logic te, input logic re, input logic st, input logic hl);
    cmd_wr = 1'b1; cmd_tx_en = te; cmd_rx_en = re; cmd_start = st; cmd_halt = hl;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_start = 1'b0; cmd_halt = 1'b0;
  endtask

  task automatic set_base(input int b);
    base_in = AW'(b); base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (tx_go && k < 3000) begin @(negedge clk); k++; end
    chk(k < 3000, req, k, 0);
    @(negedge clk);
  endtask

  // compare recorded bytes [n0, n0+len) against one buffer's pattern
  task automatic chk_bytes(input int n0, input int len, input int s, input int off,
                           input string req);
    bit ok = 1'b1;
    for (int i = 0; i < len; i++)
      if (rx_b[n0 + i] !== pat(s, i)) ok = 1'b0;
    chk(ok, req, (len > 0) ? rx_b[n0] : 0, (len > 0) ? pat(s, 0) : 0);
    if (off < 0) ;
  endtask

  initial begin
    int n0;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(!tx_go && !tx_valid && !mem_rd && !mem_we, "R5 reset idle", tx_go, 0);
    chk(rx_enable == 1'b0, "R13 reset rx_enable", rx_enable, 0);

    // sweep: lengths 0..9 under three ready patterns (R2 R3 R4 R6 R8)
    for (int m = 0; m < 3; m++) begin
      for (int len = 0; len < 10; len++) begin
        rdy_mode = m;
        do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
        set_base(0);
        c = LST | 32'(len) | ((len % 2) ? NOC : 32'd0);
        fill_buf(64, len, len + 10*m);
        wr_mem(0, 32'd64); wr_mem(1, c);
        wr_mem(2, 32'd80); wr_mem(3, OWN | LST | 32'd4);
        n0 = rx_n;
        do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
        chk(tx_go == 1'b1, "R8 tx_go after start", tx_go, 1);
        wait_idle("R5 stop at owned descriptor");
        chk(rx_n - n0 == len, "R2 byte count", rx_n - n0, len);
        chk_bytes(n0, len, len + 10*m, 0, "R2 byte order");
        if (len > 0) begin
          chk(rx_l[rx_n-1] == 1'b1, "R3 last on final byte", rx_l[rx_n-1], 1);
          chk(rx_c[n0] == (len % 2 == 1), "R4 nocrc copy", rx_c[n0], len % 2);
        end
        if (len > 1) chk(rx_l[n0] == 1'b0, "R3 no early last", rx_l[n0], 0);
        chk(mem[1] == (c | OWN), "R6 write-back owned", mem[1], c | OWN);
        chk(mem[3] == (OWN | LST | 32'd4), "R5 owned desc untouched", mem[3], OWN | LST | 4);
      end
    end
    rdy_mode = 0;

    // multi-buffer frame (R3 R6)
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    fill_buf(64, 5, 1); fill_buf(80, 3, 2); fill_buf(96, 6, 3);
    wr_mem(0, 32'd64); wr_mem(1, 32'd5);
    wr_mem(2, 32'd80); wr_mem(3, 32'd3);
    wr_mem(4, 32'd96); wr_mem(5, LST | 32'd6);
    wr_mem(6, 32'd64); wr_mem(7, OWN);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R3 multi idle");
    chk(rx_n - n0 == 14, "R3 joined length", rx_n - n0, 14);
    chk_bytes(n0, 5, 1, 0, "R3 part 1");
    chk_bytes(n0 + 5, 3, 2, 0, "R3 part 2");
    chk_bytes(n0 + 8, 6, 3, 0, "R3 part 3");
    chk(rx_l[n0+4] == 0 && rx_l[n0+7] == 0 && rx_l[n0+13] == 1, "R3 last only at end",
        {rx_l[n0+4], rx_l[n0+7], rx_l[n0+13]}, 1);
    chk(mem[1] == (OWN | 32'd5) && mem[3] == (OWN | 32'd3) && mem[5] == (OWN | LST | 32'd6),
        "R6 every buffer reclaimed", mem[3], OWN | 3);

    // wrap (R7), ring at base 8
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    set_base(8);
    fill_buf(64, 3, 4); fill_buf(80, 2, 5); fill_buf(96, 7, 6);
    wr_mem(8, 32'd64);  wr_mem(9, LST | 32'd3);
    wr_mem(10, 32'd80); wr_mem(11, LST | WRP | 32'd2);
    wr_mem(12, 32'd96); wr_mem(13, LST | 32'd7);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R7 wrap idle");
    chk(rx_n - n0 == 5, "R7 stops after wrap", rx_n - n0, 5);
    chk(mem[13] == (LST | 32'd7), "R7 past-wrap desc untouched", mem[13], LST | 7);
    fill_buf(64, 4, 7);
    wr_mem(9, LST | 32'd4);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R7 restart idle");
    chk(rx_n - n0 == 4, "R7 resumes at descriptor 0", rx_n - n0, 4);
    chk_bytes(n0, 4, 7, 0, "R7 descriptor 0 data");

    // halt (R9)
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    set_base(0);
    fill_buf(64, 8, 8); fill_buf(80, 4, 9);
    wr_mem(0, 32'd64); wr_mem(1, LST | 32'd8);
    wr_mem(2, 32'd80); wr_mem(3, LST | 32'd4);
    wr_mem(4, 32'd64); wr_mem(5, OWN);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    do_cmd(1'b1, 1'b0, 1'b0, 1'b1);
    chk(tx_go == 1'b1, "R9 busy while frame finishes", tx_go, 1);
    wait_idle("R9 halt idle");
    chk(rx_n - n0 == 8 && rx_l[rx_n-1] == 1'b1, "R9 frame completed", rx_n - n0, 8);
    chk(mem[3] == (LST | 32'd4), "R9 next frame not taken", mem[3], LST | 4);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R9 resume idle");
    chk(rx_n - n0 == 4, "R9 resume count", rx_n - n0, 4);
    chk_bytes(n0, 4, 9, 0, "R9 resume data");

    // disable (R10)
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    fill_buf(64, 2, 11); fill_buf(96, 40, 12);
    wr_mem(0, 32'd64); wr_mem(1, LST | 32'd2);
    wr_mem(2, 32'd96); wr_mem(3, LST | 32'd40);
    wr_mem(4, 32'd64); wr_mem(5, OWN);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 500 && rx_n - n0 < 8; k++) @(negedge clk);
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    chk(!tx_go && !tx_valid, "R10 immediate stop", {tx_go, tx_valid}, 0);
    chk(mem[3] == (LST | 32'd40), "R10 aborted desc not reclaimed", mem[3], LST | 40);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R10 restart idle");
    chk(rx_n == n0, "R10 index back to base", rx_n - n0, 0);

    // mid-frame owned descriptor (R11)
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    fill_buf(64, 3, 13);
    wr_mem(0, 32'd64); wr_mem(1, 32'd3);
    wr_mem(2, 32'd80); wr_mem(3, OWN | LST | 32'd2);
    n0 = rx_n;
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle("R11 abort idle");
    chk(rx_n - n0 == 3 && rx_l[rx_n-1] == 1'b0, "R11 partial without last", rx_n - n0, 3);
    chk(mem[1] == (OWN | EXH | 32'd3), "R11 exhausted flag", mem[1], OWN | EXH | 3);
    chk(mem[3] == (OWN | LST | 32'd2), "R11 blocking desc untouched", mem[3], OWN | LST | 2);

    // MAC status (R6)
    do_cmd(1'b0, 1'b0, 1'b0, 1'b0);
    fill_buf(64, 12, 14);
    wr_mem(0, 32'd64); wr_mem(1, LST | 32'd12);
    wr_mem(2, 32'd64); wr_mem(3, OWN);
    do_cmd(1'b1, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    mac_underrun = 1'b1; @(negedge clk); mac_underrun = 1'b0;
    @(negedge clk);
    mac_retry_lim = 1'b1; @(negedge clk); mac_retry_lim = 1'b0;
    wait_idle("R6 status idle");
    chk(mem[1] == (OWN | UDR | RTY | LST | 32'd12), "R6 status bits", mem[1],
        OWN | UDR | RTY | LST | 12);

    // receive enable (R13)
    do_cmd(1'b1, 1'b1, 1'b0, 1'b0);
    chk(rx_enable == 1'b1, "R13 rx_enable set", rx_enable, 1);
    chk(tx_go == 1'b0, "R8 no start without start field", tx_go, 0);
    do_cmd(1'b1, 1'b0, 1'b0, 1'b0);
    chk(rx_enable == 1'b0, "R13 rx_enable clear", rx_enable, 0);

    $display("Result: errors=%0d of %0d checks", errs + merrs, checks + mchecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errs + merrs + 1, checks + mchecks + 1);
    $finish;
  end
endmodule